// File: doc/BRIEF.md
# Power Mode Controller

This block holds the power state of a small system-on-chip. It moves between six states: initialisation, run, slow, idle, sleep and deep sleep. It also holds a small bank of control registers on a word-addressed bus. The processor changes the state by writing a 3-bit code to the mode register. The block returns to run when wake conditions occur. Interrupts end idle. A wake pin ends sleep and deep sleep. Leaving deep sleep also depends on two supply-status inputs and a software permission bit.

Because the processor only has clocks in run and slow, the bus is honoured only in those two states. A separate test read path can observe every register in any state, but only after a test-clock bit has been set. The block decodes its current state into a one-hot vector and into processor and peripheral clock enables. Registers are 8 bytes apart; the register index is address bits [5:3].

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Synchronous reset puts the block in initialisation. In that state mode_onehot is 6'b000001, both clock enables are low, the deep-sleep permission bit is 0 and reset status reads 3'b001.
- R2: In initialisation the block stays put while pll_lock is low. The clock edge that samples pll_lock high moves it to run.
- R3: In run or slow, a bus write to offset 0x00 whose bits [2:0] are slow 0, run 1, idle 2, sleep 3 or deep sleep 7 takes effect at the next edge. The same write stores bit 3 as the permission bit. A bus read of offset 0x00 returns {perm, mode}, so the mode field always reads 0 or 1.
- R4: A mode write whose bits [2:0] are 4, 5 or 6 is discarded completely: the state does not change and the permission bit keeps its value.
- R5: In idle, sleep and deep sleep, bus writes are ignored and bus reads return 0.
- R6: In idle, an input irq[i] returns the block to run when its enable bit i in the clock-control register (offset 0x28, bits [3:0]) is set. Irq inputs whose enable bit is clear have no effect.
- R7: In sleep, a high wake_pin returns the block to run at the next edge. Without it the block stays in sleep.
- R8: In deep sleep, a high wake_pin returns the block to run only if supply_a or supply_b is high, or if the permission bit is 1. When both supplies are low and the bit is 0, the block stays in deep sleep.
- R9: Reset status at offset 0x20 holds power-on (bit 0), watchdog (bit 1) and software (bit 2) causes. The inputs por_evt, wdt_evt and sw_evt set these bits. Writing 1 to a bit clears it, and a cause arriving in the same cycle as the clear wins.
- R10: Offset 0x10 reads the constant ID_VALUE (default 32'h0051_A3C0). Writes to it change nothing.
- R11: With tap_sel high, a read of any offset returns the register contents in any state, but only while bit 8 of the debounce-test register (offset 0x30, 9 bits wide) is 1. Otherwise the test read returns 0.
- R12: cpu_clk_en is high only in run and slow. per_clk_en is high in run, slow and idle. mode_onehot bits are [0] init, [1] run, [2] slow, [3] idle, [4] sleep, [5] deep sleep.
- R13: Plain registers read back what was written, masked to their width: coprocessor enable at 0x08 (bit 0), bus retract at 0x18 (bit 0) and general test at 0x38 (32 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Processor bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tap_sel | input | 1 | Test read access this cycle |
| pll_lock | input | 1 | Clock source locked |
| irq | input | 4 | Interrupt inputs, wake from idle |
| wake_pin | input | 1 | Wake from sleep or deep sleep |
| supply_a | input | 1 | Supply status A |
| supply_b | input | 1 | Supply status B |
| por_evt | input | 1 | Power-on reset cause |
| wdt_evt | input | 1 | Watchdog reset cause |
| sw_evt | input | 1 | Software reset cause |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_onehot | output | 6 | One-hot current state |

## Verification
The assertions assume that the processor bus is only used in run or slow, and that a test read asserts tap_sel without bus_wr. They also assume the permission bit cannot change during deep sleep, which holds because bus writes are blocked there. The stimulus changes every input on the falling edge and holds wake and irq pulses for exactly one cycle. It drives bus accesses in low-power states only on purpose, to show they are blocked. The supplies change only while the block sits in deep sleep, before the wake pulse is applied.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NIRQ   = 4;
    localparam int NMODE  = 6;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int DBG_W  = 9;
    localparam int RST_W  = 3;

    typedef enum logic [2:0] {
        PM_SLOW  = 3'd0,
        PM_RUN   = 3'd1,
        PM_IDLE  = 3'd2,
        PM_SLEEP = 3'd3,
        PM_INIT  = 3'd4,
        PM_DEEP  = 3'd7
    } pm_mode_e;

    typedef enum logic [IDX_W-1:0] {
        RG_MODE  = 3'd0,
        RG_COPRO = 3'd1,
        RG_ID    = 3'd2,
        RG_RETR  = 3'd3,
        RG_RSTAT = 3'd4,
        RG_CLKC  = 3'd5,
        RG_DBG   = 3'd6,
        RG_GTEST = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic     valid;
        pm_mode_e mode;
        logic     perm;
    } mode_req_t;

    function automatic logic code_defined(input logic [2:0] c);
        return (c == PM_SLOW) || (c == PM_RUN) || (c == PM_IDLE) ||
               (c == PM_SLEEP) || (c == PM_DEEP);
    endfunction

    function automatic logic cpu_awake(input pm_mode_e m);
        return (m == PM_RUN) || (m == PM_SLOW);
    endfunction

    function automatic pm_mode_e onehot_code(input int i);
        case (i)
            0:       return PM_INIT;
            1:       return PM_RUN;
            2:       return PM_SLOW;
            3:       return PM_IDLE;
            4:       return PM_SLEEP;
            default: return PM_DEEP;
        endcase
    endfunction

endpackage

// File: rtl/pmc_regbank.sv
module pmc_regbank
    import pmc_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0051_A3C0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              tap_sel,
    input  pm_mode_e          cur_mode,
    input  logic [RST_W-1:0]  rst_evt,
    output mode_req_t         mreq,
    output logic              perm,
    output logic [NIRQ-1:0]   irq_en,
    output logic              tclk_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int LOW_W = $clog2(DATA_W / 4);

    logic              aligned;
    logic [IDX_W-1:0]  idx;
    logic [NREG-1:0]   hit;
    logic              cpu_acc;
    logic              wr_en;
    logic              rd_en;

    logic              perm_q;
    logic              copro_q;
    logic              retr_q;
    logic [RST_W-1:0]  rstat_q;
    logic [NIRQ-1:0]   clkc_q;
    logic [DBG_W-1:0]  dbg_q;
    logic [DATA_W-1:0] gtest_q;

    assign aligned = (req.addr[LOW_W-1:0] == '0) &&
                     (req.addr[ADDR_W-1:LOW_W+IDX_W] == '0);
    assign idx     = req.addr[LOW_W+IDX_W-1:LOW_W];

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hit[g] = aligned && (idx == IDX_W'(g));
    end

    assign cpu_acc = req.sel && cpu_awake(cur_mode);
    assign wr_en   = cpu_acc && req.wr;
    assign rd_en   = (cpu_acc && !req.wr) || (tap_sel && dbg_q[DBG_W-1]);

    always_comb begin
        mreq.valid = wr_en && hit[RG_MODE] && code_defined(req.wdata[2:0]);
        mreq.mode  = pm_mode_e'(req.wdata[2:0]);
        mreq.perm  = req.wdata[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            perm_q  <= 1'b0;
            copro_q <= 1'b0;
            retr_q  <= 1'b0;
            clkc_q  <= '0;
            dbg_q   <= '0;
            gtest_q <= '0;
        end else if (wr_en) begin
            if (mreq.valid)   perm_q  <= mreq.perm;
            if (hit[RG_COPRO]) copro_q <= req.wdata[0];
            if (hit[RG_RETR])  retr_q  <= req.wdata[0];
            if (hit[RG_CLKC])  clkc_q  <= req.wdata[NIRQ-1:0];
            if (hit[RG_DBG])   dbg_q   <= req.wdata[DBG_W-1:0];
            if (hit[RG_GTEST]) gtest_q <= req.wdata;
        end
    end

    for (genvar b = 0; b < RST_W; b++) begin : g_rstat
        always_ff @(posedge clk) begin
            if (rst) begin
                rstat_q[b] <= (b == 0);
            end else if (rst_evt[b]) begin
                rstat_q[b] <= 1'b1;
            end else if (wr_en && hit[RG_RSTAT] && req.wdata[b]) begin
                rstat_q[b] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && aligned) begin
            case (reg_idx_e'(idx))
                RG_MODE:  rdata = DATA_W'({perm_q, cur_mode});
                RG_COPRO: rdata = DATA_W'(copro_q);
                RG_ID:    rdata = ID_VALUE;
                RG_RETR:  rdata = DATA_W'(retr_q);
                RG_RSTAT: rdata = DATA_W'(rstat_q);
                RG_CLKC:  rdata = DATA_W'(clkc_q);
                RG_DBG:   rdata = DATA_W'(dbg_q);
                RG_GTEST: rdata = gtest_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign perm    = perm_q;
    assign irq_en  = clkc_q;
    assign tclk_en = dbg_q[DBG_W-1];

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  mode_req_t       mreq,
    input  logic            perm,
    input  logic            pll_lock,
    input  logic [NIRQ-1:0] irq,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            wake_pin,
    input  logic            supply_a,
    input  logic            supply_b,
    output pm_mode_e        mode
);

    pm_mode_e mode_q;
    pm_mode_e mode_d;
    logic     deep_exit_ok;

    assign deep_exit_ok = perm || supply_a || supply_b;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            PM_INIT:          if (pll_lock) mode_d = PM_RUN;
            PM_RUN, PM_SLOW:  if (mreq.valid) mode_d = mreq.mode;
            PM_IDLE:          if (|(irq & irq_en)) mode_d = PM_RUN;
            PM_SLEEP:         if (wake_pin) mode_d = PM_RUN;
            PM_DEEP:          if (wake_pin && deep_exit_ok) mode_d = PM_RUN;
            default:          mode_d = PM_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_INIT;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/pmc_clkgate.sv
module pmc_clkgate
    import pmc_pkg::*;
(
    input  pm_mode_e         mode,
    output logic [NMODE-1:0] onehot,
    output logic             cpu_en,
    output logic             per_en
);

    for (genvar i = 0; i < NMODE; i++) begin : g_dec
        assign onehot[i] = (mode == onehot_code(i));
    end

    assign cpu_en = onehot[1] || onehot[2];
    assign per_en = cpu_en || onehot[3];

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0051_A3C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tap_sel,
    input  logic              pll_lock,
    input  logic [NIRQ-1:0]   irq,
    input  logic              wake_pin,
    input  logic              supply_a,
    input  logic              supply_b,
    input  logic              por_evt,
    input  logic              wdt_evt,
    input  logic              sw_evt,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic [NMODE-1:0]  mode_onehot
);

    bus_req_t        req;
    mode_req_t       mreq;
    pm_mode_e        cur_mode;
    logic            perm;
    logic            tclk_en;
    logic [NIRQ-1:0] irq_en;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    pmc_regbank #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .tap_sel  (tap_sel),
        .cur_mode (cur_mode),
        .rst_evt  ({sw_evt, wdt_evt, por_evt}),
        .mreq     (mreq),
        .perm     (perm),
        .irq_en   (irq_en),
        .tclk_en  (tclk_en),
        .rdata    (bus_rdata)
    );

    pmc_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mreq     (mreq),
        .perm     (perm),
        .pll_lock (pll_lock),
        .irq      (irq),
        .irq_en   (irq_en),
        .wake_pin (wake_pin),
        .supply_a (supply_a),
        .supply_b (supply_b),
        .mode     (cur_mode)
    );

    pmc_clkgate u_clk (
        .mode   (cur_mode),
        .onehot (mode_onehot),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en)
    );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode,
    input logic              perm,
    input logic              tclk_en,
    input logic              pll_lock,
    input logic              wake_pin,
    input logic              supply_a,
    input logic              supply_b,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tap_sel,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic [NMODE-1:0]  mode_onehot
);

    // R2
    init_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_INIT && pll_lock) |=> (mode == PM_RUN));

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SLEEP && !wake_pin) |=> (mode == PM_SLEEP));

    // R8
    deep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP && !perm && !supply_a && !supply_b) |=> (mode == PM_DEEP));

    // R12
    clk_order_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> per_clk_en);

    // R12
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_onehot) == 1);

    // R12
    lowpower_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_onehot[4] || mode_onehot[5]) |-> !per_clk_en);

    // R5
    blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !cpu_clk_en && !(tap_sel && tclk_en)) |-> (bus_rdata == '0));

    // R3
    cpu_mode_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == '0 && cpu_clk_en) |-> (bus_rdata[2:0] <= 3'd1));

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (cur_mode),
    .perm        (perm),
    .tclk_en     (tclk_en),
    .pll_lock    (pll_lock),
    .wake_pin    (wake_pin),
    .supply_a    (supply_a),
    .supply_b    (supply_b),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .tap_sel     (tap_sel),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .mode_onehot (mode_onehot)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;

    localparam logic [31:0] ID_EXP = 32'h0051_A3C0;
    localparam int NV = 22;

    // {write, reqnum, addr, data}
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 4'd9,  8'h20, 32'h0000_0001},  // R9 power-on bit after reset
        {1'b1, 4'd9,  8'h20, 32'h0000_0001},
        {1'b0, 4'd9,  8'h20, 32'h0000_0000},
        {1'b1, 4'd13, 8'h08, 32'hFFFF_FFFF},  // R13 copro
        {1'b0, 4'd13, 8'h08, 32'h0000_0001},
        {1'b1, 4'd13, 8'h18, 32'h0000_0003},  // R13 retract
        {1'b0, 4'd13, 8'h18, 32'h0000_0001},
        {1'b1, 4'd13, 8'h38, 32'hA5C3_0F01},  // R13 general test
        {1'b0, 4'd13, 8'h38, 32'hA5C3_0F01},
        {1'b1, 4'd10, 8'h10, 32'h0000_DEAD},  // R10 id write discarded
        {1'b0, 4'd10, 8'h10, ID_EXP},
        {1'b1, 4'd6,  8'h28, 32'hFFFF_FFF5},  // R6 enable mask width
        {1'b0, 4'd6,  8'h28, 32'h0000_0005},
        {1'b1, 4'd3,  8'h00, 32'h0000_0009},  // R3 run + perm
        {1'b0, 4'd3,  8'h00, 32'h0000_0009},
        {1'b1, 4'd4,  8'h00, 32'h0000_0005},  // R4 undefined code 5
        {1'b0, 4'd4,  8'h00, 32'h0000_0009},
        {1'b1, 4'd4,  8'h00, 32'h0000_0006},  // R4 undefined code 6, perm 0
        {1'b0, 4'd4,  8'h00, 32'h0000_0009},
        {1'b1, 4'd3,  8'h00, 32'h0000_0000},  // R3 slow
        {1'b0, 4'd3,  8'h00, 32'h0000_0000},
        {1'b1, 4'd3,  8'h00, 32'h0000_0001}   // R3 back to run
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0, tap_sel = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_lock = 0, wake_pin = 0, supply_a = 0, supply_b = 0;
    logic [3:0]  irq = '0;
    logic        por_evt = 0, wdt_evt = 0, sw_evt = 0;
    logic        cpu_clk_en, per_clk_en;
    logic [5:0]  mode_onehot;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tap_sel(tap_sel), .pll_lock(pll_lock), .irq(irq), .wake_pin(wake_pin),
        .supply_a(supply_a), .supply_b(supply_b), .por_evt(por_evt),
        .wdt_evt(wdt_evt), .sw_evt(sw_evt), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .mode_onehot(mode_onehot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bread(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic tread(input string req, input logic [7:0] a, input logic [31:0] exp);
        tap_sel = 1; bus_addr = a;
        #1 chk(req, bus_rdata, exp);
        @(negedge clk);
        tap_sel = 0;
    endtask

    task automatic pulse_wake();
        wake_pin = 1;
        @(negedge clk);
        wake_pin = 0;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 onehot", 32'(mode_onehot), 32'h01);
        chk("R1 enables", {30'b0, cpu_clk_en, per_clk_en}, 32'h0);
        tread("R1 test read blocked", 8'h00, 32'h0);
        // R2 hold in init without lock
        repeat (3) @(negedge clk);
        chk("R2 init hold", 32'(mode_onehot), 32'h01);
        pll_lock = 1;
        @(negedge clk);
        chk("R2 to run", 32'(mode_onehot), 32'h02);
        chk("R12 run enables", {30'b0, cpu_clk_en, per_clk_en}, 32'h3);
        bread("R1 perm after reset", 8'h00, 32'h1);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) bwrite(VEC[i][39:32], VEC[i][31:0]);
            else bread($sformatf("R%0d vec%0d", VEC[i][43:40], i), VEC[i][39:32], VEC[i][31:0]);
        end

        // R6 idle wake by enabled irq only
        bwrite(8'h28, 32'h2);
        bwrite(8'h00, 32'h2);
        chk("R12 idle onehot", 32'(mode_onehot), 32'h08);
        chk("R12 idle enables", {30'b0, cpu_clk_en, per_clk_en}, 32'h1);
        bwrite(8'h00, 32'h1);  // R5 ignored in idle
        chk("R5 write ignored", 32'(mode_onehot), 32'h08);
        bread("R5 read zero", 8'h10, 32'h0);
        irq = 4'b0001;
        @(negedge clk);
        irq = '0;
        chk("R6 masked irq", 32'(mode_onehot), 32'h08);
        irq = 4'b0010;
        @(negedge clk);
        irq = '0;
        chk("R6 enabled irq", 32'(mode_onehot), 32'h02);

        // R7 sleep
        bwrite(8'h00, 32'h3);
        chk("R12 sleep onehot", 32'(mode_onehot), 32'h10);
        chk("R12 sleep enables", {30'b0, cpu_clk_en, per_clk_en}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R7 sleep hold", 32'(mode_onehot), 32'h10);
        tread("R11 tclk off", 8'h00, 32'h0);
        pulse_wake();
        chk("R7 wake", 32'(mode_onehot), 32'h02);

        // R11 test reads with test clock bit
        bwrite(8'h30, 32'h100);
        bwrite(8'h00, 32'h3);
        tread("R11 mode in sleep", 8'h00, 32'h3);
        tread("R11 dbg reg", 8'h30, 32'h100);
        pulse_wake();
        bwrite(8'h30, 32'h0);

        // R8 deep sleep, perm 0
        bwrite(8'h00, 32'h7);
        chk("R12 deep onehot", 32'(mode_onehot), 32'h20);
        pulse_wake();
        chk("R8 blocked", 32'(mode_onehot), 32'h20);
        supply_b = 1;
        pulse_wake();
        chk("R8 supply high exit", 32'(mode_onehot), 32'h02);
        supply_b = 0;
        bwrite(8'h00, 32'hF);
        pulse_wake();
        chk("R8 perm exit", 32'(mode_onehot), 32'h02);

        // R9 causes and write-one-to-clear
        bwrite(8'h20, 32'h7);
        wdt_evt = 1;
        @(negedge clk);
        wdt_evt = 0;
        bread("R9 wdt set", 8'h20, 32'h2);
        sw_evt = 1;
        bwrite(8'h20, 32'h4);
        sw_evt = 0;
        bread("R9 set wins", 8'h20, 32'h6);
        bwrite(8'h20, 32'h2);
        bread("R9 clear one", 8'h20, 32'h4);
        por_evt = 1;
        @(negedge clk);
        por_evt = 0;
        bread("R9 por", 8'h20, 32'h5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule